// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block drives the offset that a PLL feedback divider adds to its nominal value so that the synthesized clock wanders slightly below its target frequency. Spreading the energy of the clock over a band in this way lowers the peak of its emitted spectrum. The offset moves in discrete steps. A prescaler divides the base clock into fixed time units, nominally 280 ns each, and a programmable count of those units sets the time between steps.

An 8-bit slope word sets the size of each step. Its upper nibble is the unsigned rise step. Its lower nibble is the fall step, held in two's complement. Internally the block keeps a non-negative depth and drives the offset as the negated depth, so the spread only ever lowers the frequency. A profile select input chooses one of two shapes. In the pendulum shape the depth sweeps up to a peak limit and back down to zero. In the original shape it climbs to the peak and then falls straight back to zero. When spreading is switched off, the offset is zero and all timing restarts.

Top module: `ssc_profile_gen`

## Requirements
- R1: During reset and after it, offsetOut is 0 and spreadOn is 0 until the enable is seen.
- R2: While spreadEn is low, offsetOut reads 0 from the next cycle on. The step timer and the profile direction are cleared, so after spreadEn rises again the first step lands exactly UNIT_CYCLES × interval cycles later.
- R3: offsetOut changes only on the clock edge that ends each step period. A period is UNIT_CYCLES × intervalCfg base cycles, and an intervalCfg of 0 behaves as 1.
- R4: While rising, each step adds the unsigned value slopeCfg[7:4] to the depth. When the sum reaches or passes peakLimit, the depth is set to peakLimit and the profile turns to falling.
- R5: The fall step is slopeCfg[3:0] read as a negative two's-complement number, with magnitude (16 − field) mod 16. So 1111 gives 1, 1110 gives 2, 1001 gives 7 and 1000 gives 8.
- R6: With profileSel = 1 (pendulum), each falling step subtracts the fall magnitude. When the result would be zero or below, the depth becomes 0 and the profile turns to rising.
- R7: With profileSel = 0 (original), the step after the peak is reached sets the depth directly to 0 and the profile turns to rising.
- R8: offsetOut equals the negated depth. It is never positive and never below −peakLimit.
- R9: spreadOn equals spreadEn delayed by one clock cycle.
- R10: With the default slope word 0x0E (rise step 0, fall step 2), the offset stays at 0 while spreading is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spreadEn | input | 1 | Turns spreading on |
| profileSel | input | 1 | 1 = pendulum profile, 0 = original profile |
| slopeCfg | input | 2*SLOPE_W | [7:4] unsigned rise step, [3:0] two's-complement fall step |
| intervalCfg | input | IVL_W | Step interval in prescaler units (0 acts as 1) |
| peakLimit | input | DEPTH_W | Largest depth the profile reaches |
| offsetOut | output | DEPTH_W+1 | Signed divider offset, 0 or negative |
| spreadOn | output | 1 | Registered copy of the enable |

## Verification
The checker assumes that intervalCfg and peakLimit change only while spreadEn is low. This matters for two reasons. Its step-period counter only tracks the programmed interval while that value is stable. And a peak lowered below the current depth would leave the offset out of bounds until the next step. The stimulus reprograms the interval and the peak only after dropping the enable for at least one cycle. The slope word and the profile select are free to change, because they take effect only at a step edge.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // Strobes passed from the timing control to the depth datapath.
  typedef struct packed {
    logic step;   // apply one profile step on this edge
    logic clear;  // spreading is off: return depth and direction to rest
  } ssc_strobe_t;
endpackage

// File: rtl/ssc_tick_ctrl.sv
module ssc_tick_ctrl
  import ssc_pkg::*;
#(
  parameter int UNIT_CYCLES = 56,
  parameter int IVL_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [IVL_W-1:0] intervalCfg,
  output ssc_strobe_t      strobe
);
  localparam int PRE_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_CYCLES - 1);

  logic [PRE_W-1:0] preCnt;
  logic [IVL_W-1:0] unitCnt;
  logic [IVL_W-1:0] unitLast;
  logic             unitTick;
  logic             stepHit;

  // A zero interval is treated as a single unit.
  assign unitLast = (intervalCfg == '0) ? '0 : intervalCfg - IVL_W'(1);
  assign unitTick = enable && (preCnt == PRE_LAST);
  // The >= comparison keeps the counter from running past a shrunk interval.
  assign stepHit  = unitTick && (unitCnt >= unitLast);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      preCnt  <= '0;
      unitCnt <= '0;
    end else begin
      preCnt <= unitTick ? '0 : preCnt + PRE_W'(1);
      if (stepHit)       unitCnt <= '0;
      else if (unitTick) unitCnt <= unitCnt + IVL_W'(1);
    end
  end

  assign strobe.step  = stepHit;
  assign strobe.clear = !enable;
endmodule

// File: rtl/ssc_depth_path.sv
module ssc_depth_path
  import ssc_pkg::*;
#(
  parameter int DEPTH_W = 8,
  parameter int SLOPE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ssc_strobe_t        strobe,
  input  logic               pendulum,
  input  logic [SLOPE_W-1:0] upStep,
  input  logic [SLOPE_W-1:0] downStep,
  input  logic [DEPTH_W-1:0] peakLimit,
  output logic [DEPTH_W-1:0] depth
);
  localparam int SUM_W = DEPTH_W + 1;

  logic               falling;
  logic [SLOPE_W-1:0] downMag;
  logic [SUM_W-1:0]   riseSum;
  logic               reachPeak;
  logic               reachZero;

  // Negating the two's-complement field gives the fall magnitude.
  assign downMag   = ~downStep + SLOPE_W'(1);
  assign riseSum   = {1'b0, depth} + SUM_W'(upStep);
  assign reachPeak = riseSum >= {1'b0, peakLimit};
  assign reachZero = {1'b0, depth} <= SUM_W'(downMag);

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clear) begin
      depth   <= '0;
      falling <= 1'b0;
    end else if (strobe.step) begin
      if (!falling) begin
        if (reachPeak) begin
          depth   <= peakLimit;
          falling <= 1'b1;
        end else begin
          depth <= riseSum[DEPTH_W-1:0];
        end
      end else if (!pendulum || reachZero) begin
        depth   <= '0;
        falling <= 1'b0;
      end else begin
        depth <= depth - DEPTH_W'(downMag);
      end
    end
  end
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int UNIT_CYCLES = 56,
  parameter int IVL_W       = 6,
  parameter int DEPTH_W     = 8,
  parameter int SLOPE_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spreadEn,
  input  logic                      profileSel,
  input  logic [2*SLOPE_W-1:0]      slopeCfg,
  input  logic [IVL_W-1:0]          intervalCfg,
  input  logic [DEPTH_W-1:0]        peakLimit,
  output logic signed [DEPTH_W:0]   offsetOut,
  output logic                      spreadOn
);
  ssc_strobe_t        strobe;
  logic [DEPTH_W-1:0] depth;

  ssc_tick_ctrl #(.UNIT_CYCLES(UNIT_CYCLES), .IVL_W(IVL_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .enable(spreadEn),
    .intervalCfg(intervalCfg), .strobe(strobe)
  );

  ssc_depth_path #(.DEPTH_W(DEPTH_W), .SLOPE_W(SLOPE_W)) path_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pendulum(profileSel),
    .upStep(slopeCfg[2*SLOPE_W-1:SLOPE_W]), .downStep(slopeCfg[SLOPE_W-1:0]),
    .peakLimit(peakLimit), .depth(depth)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) spreadOn <= 1'b0;
    else        spreadOn <= spreadEn;
  end

  // Spread is downward only: the offset is the negated depth.
  assign offsetOut = $signed((DEPTH_W+1)'(0) - {1'b0, depth});
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
  parameter int UNIT_CYCLES = 56,
  parameter int IVL_W       = 6,
  parameter int DEPTH_W     = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    spreadEn,
  input logic [IVL_W-1:0]        intervalCfg,
  input logic [DEPTH_W-1:0]      peakLimit,
  input logic signed [DEPTH_W:0] offsetOut,
  input logic                    spreadOn
);
  int phase;
  int stepAt;

  assign stepAt = UNIT_CYCLES * ((intervalCfg == '0) ? 1 : int'(intervalCfg)) - 1;

  // Counts enabled cycles inside the current step period.
  always_ff @(posedge clk) begin
    if (!rst_n || !spreadEn) phase <= 0;
    else if (phase >= stepAt) phase <= 0;
    else phase <= phase + 1;
  end

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !spreadEn |=> offsetOut == '0);

  p_hold_between_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spreadEn && phase != stepAt) |=> $stable(offsetOut));

  p_offset_bounds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(offsetOut) <= 0) && (int'(offsetOut) + int'(peakLimit) >= 0));

  p_on_follows_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> spreadOn == $past(spreadEn));
endmodule

bind ssc_profile_gen ssc_profile_chk #(
  .UNIT_CYCLES(UNIT_CYCLES), .IVL_W(IVL_W), .DEPTH_W(DEPTH_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .spreadEn(spreadEn), .intervalCfg(intervalCfg),
  .peakLimit(peakLimit), .offsetOut(offsetOut), .spreadOn(spreadOn)
);

// File: tb/ssc_profile_gen_tb_top.sv
`timescale 1ns/1ps
module ssc_profile_gen_tb_top;
  localparam int UNITS   = 3;
  localparam int IVL_W   = 6;
  localparam int DEPTH_W = 8;
  localparam int SLOPE_W = 4;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    spreadEn;
  logic                    profileSel;
  logic [2*SLOPE_W-1:0]    slopeCfg;
  logic [IVL_W-1:0]        intervalCfg;
  logic [DEPTH_W-1:0]      peakLimit;
  logic signed [DEPTH_W:0] offsetOut;
  logic                    spreadOn;

  int    checks   = 0;
  int    failures = 0;
  bit    done     = 0;
  bit    cmpOn    = 0;
  string cmpTag   = "R8";

  // Behavioural reference state.
  int mDepth = 0;
  int mFalling = 0;
  int mCnt = 0;
  int mOn = 0;

  always #2.5 clk = ~clk;

  ssc_profile_gen #(.UNIT_CYCLES(UNITS), .IVL_W(IVL_W), .DEPTH_W(DEPTH_W),
                    .SLOPE_W(SLOPE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .spreadEn(spreadEn), .profileSel(profileSel),
    .slopeCfg(slopeCfg), .intervalCfg(intervalCfg), .peakLimit(peakLimit),
    .offsetOut(offsetOut), .spreadOn(spreadOn)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: one step per UNITS*interval enabled edges.
  always @(posedge clk) begin
    if (!rst_n) begin
      mDepth = 0; mFalling = 0; mCnt = 0; mOn = 0;
    end else begin
      mOn = spreadEn;
      if (!spreadEn) begin
        mDepth = 0; mFalling = 0; mCnt = 0;
      end else begin
        mCnt++;
        if (mCnt == UNITS * ((intervalCfg == 0) ? 1 : int'(intervalCfg))) begin
          int up, mag, nd;
          mCnt = 0;
          up  = int'(slopeCfg[7:4]);
          mag = (16 - int'(slopeCfg[3:0])) % 16;
          if (mFalling == 0) begin
            nd = mDepth + up;
            if (nd >= int'(peakLimit)) begin mDepth = int'(peakLimit); mFalling = 1; end
            else mDepth = nd;
          end else if (profileSel) begin
            nd = mDepth - mag;
            if (nd <= 0) begin mDepth = 0; mFalling = 0; end
            else mDepth = nd;
          end else begin
            mDepth = 0; mFalling = 0;
          end
        end
      end
    end
  end

  // Per-clock comparison, sampled away from the active edge.
  always @(negedge clk) begin
    if (cmpOn && rst_n && !done) begin
      check(cmpTag, int'(offsetOut), -mDepth);
      check("R9", int'(spreadOn), mOn);
    end
  end

  task automatic runSteps(int n, int ivl);
    repeat (n * UNITS * ((ivl == 0) ? 1 : ivl)) @(negedge clk);
  endtask

  task automatic stopSpread();
    spreadEn = 1'b0;
    @(negedge clk);
    check("R2", int'(offsetOut), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; spreadEn = 1'b0; profileSel = 1'b1; slopeCfg = 8'h0E;
    intervalCfg = 6'd2; peakLimit = 8'd10;
    repeat (3) @(negedge clk);
    check("R1", int'(offsetOut), 0);
    check("R1", int'(spreadOn), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(offsetOut), 0);
    cmpOn = 1;

    // R10: default slope word leaves the offset at zero.
    spreadEn = 1'b1;
    runSteps(5, 2);
    check("R10", int'(offsetOut), 0);
    check("R9", int'(spreadOn), 1);
    stopSpread();
    check("R9", int'(spreadOn), 0);

    // Pendulum, rise 4, fall 2 (1110), peak 10.
    slopeCfg = 8'h4E; spreadEn = 1'b1;
    runSteps(2, 2);  check("R4", int'(offsetOut), -8);
    runSteps(1, 2);  check("R4", int'(offsetOut), -10);
    runSteps(1, 2);  check("R5", int'(offsetOut), -8);
    runSteps(4, 2);  check("R6", int'(offsetOut), 0);
    runSteps(1, 2);  check("R6", int'(offsetOut), -4);
    repeat (5) @(negedge clk); check("R3", int'(offsetOut), -4);
    @(negedge clk);            check("R3", int'(offsetOut), -8);
    stopSpread();
    // R2: timing restarts after re-enable.
    spreadEn = 1'b1;
    repeat (5) @(negedge clk); check("R2", int'(offsetOut), 0);
    @(negedge clk);            check("R2", int'(offsetOut), -4);
    stopSpread();

    // R7: original profile, rise 3, peak 9.
    profileSel = 1'b0; slopeCfg = 8'h38; peakLimit = 8'd9;
    @(negedge clk); spreadEn = 1'b1;
    runSteps(3, 2);  check("R7", int'(offsetOut), -9);
    runSteps(1, 2);  check("R7", int'(offsetOut), 0);
    runSteps(1, 2);  check("R7", int'(offsetOut), -3);
    stopSpread();

    // R5: fall field 1000 is magnitude 8, 1111 is magnitude 1.
    profileSel = 1'b1; slopeCfg = 8'hF8; peakLimit = 8'd15;
    @(negedge clk); spreadEn = 1'b1;
    runSteps(1, 2);  check("R4", int'(offsetOut), -15);
    runSteps(1, 2);  check("R5", int'(offsetOut), -7);
    runSteps(1, 2);  check("R6", int'(offsetOut), 0);
    stopSpread();
    slopeCfg = 8'hFF; spreadEn = 1'b1;
    runSteps(1, 2);  check("R5", int'(offsetOut), -15);
    runSteps(1, 2);  check("R5", int'(offsetOut), -14);
    stopSpread();

    // R3: interval 0 acts as one unit.
    intervalCfg = 6'd0; slopeCfg = 8'h5E; peakLimit = 8'd20;
    @(negedge clk); spreadEn = 1'b1;
    repeat (2) @(negedge clk); check("R3", int'(offsetOut), 0);
    @(negedge clk);            check("R3", int'(offsetOut), -5);
    stopSpread();

    // R8: mixed sweeps checked against the model every clock.
    cmpTag = "R8";
    for (int k = 0; k < 6; k++) begin
      intervalCfg = 6'(1 + k % 3);
      peakLimit   = 8'(12 + 7 * k);
      profileSel  = k[0];
      slopeCfg    = 8'(8'h19 + 8'h23 * k);
      @(negedge clk); spreadEn = 1'b1;
      runSteps(30, int'(intervalCfg));
      slopeCfg = 8'(slopeCfg ^ 8'h5A);
      runSteps(20, int'(intervalCfg));
      stopSpread();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule